// File: doc/BRIEF.md
# Paged Special-Register Window Selector

This block decides which page of a paged special-register space the processor currently sees. Every paged register access elsewhere in the chip is decoded against the page value this block drives, so one bus address can reach different peripheral registers depending on that value. Software changes the page by writing a page-select register. That register answers at one fixed bus address whatever page is active, and it reads back the same way.

When the interrupt controller takes an interrupt, it pulses an entry strobe with the source number. The block then switches to the page that holds that source's flag register, so the service routine can reach its flag without first selecting a page. The page that was active before the switch goes onto a shallow save stack. An interrupt-return strobe pops the stack and puts that page back. The stack is two entries deep by default, which allows one higher-priority interrupt to nest inside a lower-priority one.

A control register holds an auto-switch enable bit. The bit is set after reset. When software clears it, interrupts no longer touch the page.

Top module: `sfr_page_ctl`

## Requirements
- R1: After synchronous reset, `cur_page` is 0x00, `rd_data` is 0x00, the auto-switch enable bit is 1 and the save stack is empty.
- R2: A write strobe at address `PAGE_ADDR` (0x84) loads `bus_wdata` into the page register, whatever page is active. A write to any other address except `CTRL_ADDR` leaves the page unchanged. The new page appears on `cur_page` after the clock edge that samples the write.
- R3: `rd_data` is registered. One edge after `bus_addr` is presented, it holds the page value at `PAGE_ADDR`, the enable bit in bit 0 at `CTRL_ADDR` (0x85) with the upper bits zero, and 0x00 at any other address.
- R4: With auto-switch on, an entry pulse sets the page from `irq_src`. Sources 0 to 8 map to 0x00 (timers 0/1/2, UART A, SPI, ADC A conversion, ADC A window, DAC A, counter array). Sources 9 to 12 map to 0x01 (comparator A, UART B, timer 3, DAC B). Sources 13 to 15 map to 0x02 (comparator B, ADC B, timer 4). Source 16 (clock multiplier lock) maps to 0x0F. Every other number maps to 0x00.
- R5: With auto-switch on, each entry pushes the prior page. Each return restores the most recently pushed page and removes it. Two nested entries unwind in reverse order.
- R6: An entry while the stack is full discards the oldest saved page. A return while the stack is empty leaves the page unchanged.
- R7: With auto-switch off, entry and return pulses change neither the page nor the stack.
- R8: A page write and an entry in the same cycle: the written value is pushed, and the page becomes the source's mapped page.
- R9: A page write and a return that restores in the same cycle: the restored page wins and the written value is discarded.
- R10: An entry and a return in the same cycle: the entry is carried out and the return is ignored.
- R11: A write at `CTRL_ADDR` sets the auto-switch enable bit from bit 0 of `bus_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register bus address, for both write and read |
| bus_wdata | input | 8 | Register bus write data |
| bus_wr | input | 1 | Write strobe |
| irq_enter | input | 1 | Single-cycle interrupt-entry pulse |
| irq_src | input | 5 | Number of the interrupt source being entered |
| irq_return | input | 1 | Single-cycle interrupt-return pulse |
| cur_page | output | 8 | Active page, decoded by all paged registers |
| rd_data | output | 8 | Registered read data for the page and control registers |

## Verification
The bound checker watches every cycle for the following: the switch to the mapped page on an enabled entry, a plain page write landing, the page holding steady while auto-switch is off, the readback of the page register, and the stack count stepping by one on each push and pop without passing its depth. The bench's scenarios are the only place to see that nested entries unwind in the right order, that overflow drops the oldest page, and that an underflowing return is harmless. The same holds for how same-cycle collisions resolve between a write, an entry and a return, and for the reset values.

// File: rtl/sfr_page_pkg.sv
package sfr_page_pkg;

  typedef logic [7:0] page_t;

  // Interrupt source numbering seen on irq_src
  typedef enum logic [4:0] {
    SRC_TMR0     = 5'd0,
    SRC_TMR1     = 5'd1,
    SRC_UART_A   = 5'd2,
    SRC_SPI      = 5'd3,
    SRC_ADCA_EOC = 5'd4,
    SRC_ADCA_WIN = 5'd5,
    SRC_DAC_A    = 5'd6,
    SRC_CNTARR   = 5'd7,
    SRC_TMR2     = 5'd8,
    SRC_CMP_A    = 5'd9,
    SRC_UART_B   = 5'd10,
    SRC_TMR3     = 5'd11,
    SRC_DAC_B    = 5'd12,
    SRC_CMP_B    = 5'd13,
    SRC_ADC_B    = 5'd14,
    SRC_TMR4     = 5'd15,
    SRC_PLL_LOCK = 5'd16
  } irq_src_e;

  localparam page_t PG_BASE   = 8'h00;
  localparam page_t PG_EXT_A  = 8'h01;
  localparam page_t PG_EXT_B  = 8'h02;
  localparam page_t PG_SYSCFG = 8'h0F;

  // Page that holds the flag register of a given interrupt source
  function automatic page_t flag_page(input logic [4:0] src);
    page_t p;
    case (src)
      SRC_CMP_A, SRC_UART_B, SRC_TMR3, SRC_DAC_B: p = PG_EXT_A;
      SRC_CMP_B, SRC_ADC_B, SRC_TMR4:             p = PG_EXT_B;
      SRC_PLL_LOCK:                               p = PG_SYSCFG;
      default:                                    p = PG_BASE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sfr_page_map.sv
module sfr_page_map
  import sfr_page_pkg::*;
#(
  parameter int SRC_W = 5
) (
  input  logic [SRC_W-1:0] src,
  output page_t            page
);
  localparam int MAP_W = 5;

  logic [MAP_W-1:0] src_n;

  generate
    if (SRC_W > MAP_W) begin : g_wide
      // numbers beyond the mapped range fall to the base page
      logic hi_set;
      assign hi_set = |src[SRC_W-1:MAP_W];
      assign src_n  = hi_set ? 5'd31 : src[MAP_W-1:0];
    end else if (SRC_W == MAP_W) begin : g_same
      assign src_n = src;
    end else begin : g_narrow
      assign src_n = {{(MAP_W-SRC_W){1'b0}}, src};
    end
  endgenerate

  always_comb begin
    page = flag_page(src_n);
  end

endmodule

// File: rtl/sfr_page_stack.sv
module sfr_page_stack
  import sfr_page_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  page_t            push_val,
  output page_t            top,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  page_t            slot [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  // Slot 0 is the newest entry; push shifts toward the tail, pop toward the head
  always_ff @(posedge clk) begin
    if (rst) begin
      slot[0] <= PG_BASE;
    end else if (push) begin
      slot[0] <= push_val;
    end else if (pop) begin
      if (DEPTH > 1) slot[0] <= slot[1 % DEPTH];
    end
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          slot[i] <= PG_BASE;
        end else if (push) begin
          slot[i] <= slot[i-1];
        end else if (pop) begin
          if (i == DEPTH - 1) slot[i] <= PG_BASE;
          else                slot[i] <= slot[(i+1) % DEPTH];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push) begin
      if (cnt_q != FULL_CNT) cnt_q <= cnt_q + 1'b1;
    end else if (pop) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top   = slot[0];
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

endmodule

// File: rtl/sfr_page_regs.sv
module sfr_page_regs
  import sfr_page_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  PAGE_ADDR = 8'h84,
  parameter logic [7:0]  CTRL_ADDR = 8'h85
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  page_t             bus_wdata,
  input  logic              bus_wr,
  input  logic              switch_go,
  input  page_t             switch_page,
  input  logic              restore_go,
  input  page_t             restore_page,
  output page_t             cur_page,
  output logic              auto_en,
  output logic              page_wr,
  output page_t             rd_data
);
  localparam logic [ADDR_W-1:0] PG_A = ADDR_W'(PAGE_ADDR);
  localparam logic [ADDR_W-1:0] CT_A = ADDR_W'(CTRL_ADDR);

  page_t page_q;
  logic  en_q;
  page_t rd_q;
  logic  ctrl_wr;

  assign page_wr = bus_wr && (bus_addr == PG_A);
  assign ctrl_wr = bus_wr && (bus_addr == CT_A);

  // Priority: interrupt entry, then restore on return, then software write
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= PG_BASE;
    end else if (switch_go) begin
      page_q <= switch_page;
    end else if (restore_go) begin
      page_q <= restore_page;
    end else if (page_wr) begin
      page_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b1;
    end else if (ctrl_wr) begin
      en_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (bus_addr)
        PG_A:    rd_q <= page_q;
        CT_A:    rd_q <= {7'b0, en_q};
        default: rd_q <= '0;
      endcase
    end
  end

  assign cur_page = page_q;
  assign auto_en  = en_q;
  assign rd_data  = rd_q;

endmodule

// File: rtl/sfr_page_ctl.sv
module sfr_page_ctl
  import sfr_page_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         SRC_W     = 5,
  parameter int         DEPTH     = 2,
  parameter logic [7:0] PAGE_ADDR = 8'h84,
  parameter logic [7:0] CTRL_ADDR = 8'h85
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              irq_enter,
  input  logic [SRC_W-1:0]  irq_src,
  input  logic              irq_return,
  output logic [7:0]        cur_page,
  output logic [7:0]        rd_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  page_t            mapped_page;
  page_t            saved_top;
  page_t            push_val;
  logic             auto_en;
  logic             page_wr;
  logic             stk_empty;
  logic [CNT_W-1:0] stk_cnt;
  logic             enter_go;
  logic             restore_go;

  assign enter_go   = irq_enter && auto_en;
  assign restore_go = irq_return && auto_en && !irq_enter && !stk_empty;
  // a write in the entry cycle is what gets saved
  assign push_val   = page_wr ? bus_wdata : cur_page;

  sfr_page_map #(.SRC_W(SRC_W)) u_map (
    .src  (irq_src),
    .page (mapped_page)
  );

  sfr_page_stack #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (enter_go),
    .pop      (restore_go),
    .push_val (push_val),
    .top      (saved_top),
    .empty    (stk_empty),
    .count    (stk_cnt)
  );

  sfr_page_regs #(
    .ADDR_W    (ADDR_W),
    .PAGE_ADDR (PAGE_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .switch_go    (enter_go),
    .switch_page  (mapped_page),
    .restore_go   (restore_go),
    .restore_page (saved_top),
    .cur_page     (cur_page),
    .auto_en      (auto_en),
    .page_wr      (page_wr),
    .rd_data      (rd_data)
  );

endmodule

// File: rtl/sfr_page_ctl_chk.sv
module sfr_page_ctl_chk
  import sfr_page_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         SRC_W     = 5,
  parameter int         DEPTH     = 2,
  parameter int         CNT_W     = 2,
  parameter logic [7:0] PAGE_ADDR = 8'h84
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              irq_enter,
  input logic [SRC_W-1:0]  irq_src,
  input logic              irq_return,
  input logic [7:0]        cur_page,
  input logic [7:0]        rd_data,
  input logic              auto_en,
  input logic [CNT_W-1:0]  stk_cnt
);
  localparam logic [ADDR_W-1:0] PG_A = ADDR_W'(PAGE_ADDR);

  logic pg_write;
  assign pg_write = bus_wr && (bus_addr == PG_A);

  AST_ENTRY_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (irq_enter && auto_en && SRC_W <= 5) |=> (cur_page == flag_page(5'($past(irq_src))))); // R4

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (pg_write && !irq_enter && !irq_return) |=> (cur_page == $past(bus_wdata))); // R2

  AST_AUTO_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && !pg_write) |=> $stable(cur_page)); // R7

  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == PG_A) |=> (rd_data == $past(cur_page))); // R3

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    (irq_enter && auto_en && stk_cnt != CNT_W'(DEPTH)) |=> (stk_cnt == $past(stk_cnt) + 1'b1)); // R5

  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (irq_return && !irq_enter && auto_en && stk_cnt != '0) |=> (stk_cnt == $past(stk_cnt) - 1'b1)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (stk_cnt <= CNT_W'(DEPTH))); // R6

  AST_EMPTY_RETURN: assert property (@(posedge clk) disable iff (rst)
    (irq_return && !irq_enter && !pg_write && stk_cnt == '0) |=> $stable(cur_page)); // R6

endmodule

bind sfr_page_ctl sfr_page_ctl_chk #(
  .ADDR_W    (ADDR_W),
  .SRC_W     (SRC_W),
  .DEPTH     (DEPTH),
  .CNT_W     (CNT_W),
  .PAGE_ADDR (PAGE_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_wr     (bus_wr),
  .irq_enter  (irq_enter),
  .irq_src    (irq_src),
  .irq_return (irq_return),
  .cur_page   (cur_page),
  .rd_data    (rd_data),
  .auto_en    (auto_en),
  .stk_cnt    (stk_cnt)
);

// File: tb/test_sfr_page_ctl.sv
`timescale 1ns/1ps
module test_sfr_page_ctl;

  localparam logic [7:0] PG_A  = 8'h84;
  localparam logic [7:0] CT_A  = 8'h85;
  localparam logic [7:0] IDLE  = 8'h00;

  // vector: req[35:32] wr[31] addr[30:23] wdata[22:15] enter[14] src[13:9] ret[8] exp[7:0]
  function automatic logic [35:0] mk(input int req, input bit wr, input logic [7:0] a,
                                     input logic [7:0] d, input bit en, input logic [4:0] s,
                                     input bit rt, input logic [7:0] e);
    return {4'(req), wr, a, d, en, s, rt, e};
  endfunction

  localparam int NV = 24;
  localparam logic [35:0] VEC [NV] = '{
    mk(2,  1, PG_A, 8'h02, 0, 5'd0,  0, 8'h02), // R2 write page
    mk(2,  1, 8'h90,8'h55, 0, 5'd0,  0, 8'h02), // R2 other address ignored
    mk(4,  0, IDLE, 8'h00, 1, 5'd10, 0, 8'h01), // R4 UART B -> 0x01
    mk(4,  0, IDLE, 8'h00, 1, 5'd16, 0, 8'h0F), // R4 nested, lock -> 0x0F
    mk(5,  0, IDLE, 8'h00, 0, 5'd0,  1, 8'h01), // R5 unwind inner
    mk(5,  0, IDLE, 8'h00, 0, 5'd0,  1, 8'h02), // R5 unwind outer
    mk(6,  0, IDLE, 8'h00, 0, 5'd0,  1, 8'h02), // R6 empty return
    mk(8,  1, PG_A, 8'h0F, 1, 5'd0,  0, 8'h00), // R8 write+entry
    mk(8,  0, IDLE, 8'h00, 0, 5'd0,  1, 8'h0F), // R8 written value restored
    mk(4,  0, IDLE, 8'h00, 1, 5'd14, 0, 8'h02), // R4 ADC B -> 0x02
    mk(9,  1, PG_A, 8'h07, 0, 5'd0,  1, 8'h0F), // R9 restore beats write
    mk(10, 0, IDLE, 8'h00, 1, 5'd13, 1, 8'h02), // R10 entry beats return
    mk(10, 0, IDLE, 8'h00, 0, 5'd0,  1, 8'h0F), // R10 one entry was pushed
    mk(4,  0, IDLE, 8'h00, 1, 5'd5,  0, 8'h00), // R4 ADC A window -> 0x00
    mk(4,  0, IDLE, 8'h00, 1, 5'd11, 0, 8'h01), // R4 timer 3 -> 0x01
    mk(6,  0, IDLE, 8'h00, 1, 5'd9,  0, 8'h01), // R6 push when full
    mk(6,  0, IDLE, 8'h00, 0, 5'd0,  1, 8'h01), // R6 pop newest
    mk(6,  0, IDLE, 8'h00, 0, 5'd0,  1, 8'h00), // R6 pop next
    mk(6,  0, IDLE, 8'h00, 0, 5'd0,  1, 8'h00), // R6 oldest 0x0F was dropped
    mk(2,  1, PG_A, 8'h0F, 0, 5'd0,  0, 8'h0F), // R2 write page
    mk(4,  0, IDLE, 8'h00, 1, 5'd31, 0, 8'h00), // R4 unmapped -> 0x00
    mk(5,  0, IDLE, 8'h00, 0, 5'd0,  1, 8'h0F), // R5 restore
    mk(4,  0, IDLE, 8'h00, 1, 5'd15, 0, 8'h02), // R4 timer 4 -> 0x02
    mk(5,  0, IDLE, 8'h00, 0, 5'd0,  1, 8'h0F)  // R5 restore
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr;
  logic       irq_enter;
  logic [4:0] irq_src;
  logic       irq_return;
  logic [7:0] cur_page;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sfr_page_ctl i_sfr_page_ctl (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .irq_enter  (irq_enter),
    .irq_src    (irq_src),
    .irq_return (irq_return),
    .cur_page   (cur_page),
    .rd_data    (rd_data)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    bus_addr = IDLE; bus_wdata = 8'h00; bus_wr = 1'b0;
    irq_enter = 1'b0; irq_src = 5'd0; irq_return = 1'b0;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a;
    step();
    v = rd_data;
    bus_addr = IDLE;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    // R1 reset state
    check("R1 page after reset", cur_page, 8'h00);
    check("R1 rd_data after reset", rd_data, 8'h00);
    read_reg(CT_A, v);
    check("R1 auto enable after reset", v, 8'h01);
    // R1 empty stack: a return leaves page alone
    irq_return = 1'b1; step(); idle();
    check("R1 stack empty after reset", cur_page, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] x;
      x = VEC[i];
      bus_wr    = x[31];
      bus_addr  = x[30:23];
      bus_wdata = x[22:15];
      irq_enter = x[14];
      irq_src   = x[13:9];
      irq_return= x[8];
      step();
      idle();
      checks++;
      if (cur_page !== x[7:0]) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=0x%02h expected=0x%02h",
                 x[35:32], i, cur_page, x[7:0]);
      end
    end

    // R3 readback of page, control and an unmapped address
    read_reg(PG_A, v);
    check("R3 page readback", v, 8'h0F);
    read_reg(CT_A, v);
    check("R3 control readback", v, 8'h01);
    read_reg(8'h33, v);
    check("R3 other address reads zero", v, 8'h00);

    // R11 and R7: auto-switch off
    bus_wr = 1'b1; bus_addr = CT_A; bus_wdata = 8'hFE; step(); idle();
    read_reg(CT_A, v);
    check("R11 enable cleared", v, 8'h00);
    irq_enter = 1'b1; irq_src = 5'd10; step(); idle();
    check("R7 entry ignored when off", cur_page, 8'h0F);
    irq_return = 1'b1; step(); idle();
    check("R7 return ignored when off", cur_page, 8'h0F);
    bus_wr = 1'b1; bus_addr = PG_A; bus_wdata = 8'h01; step(); idle();
    check("R2 write works when off", cur_page, 8'h01);
    bus_wr = 1'b1; bus_addr = CT_A; bus_wdata = 8'h01; step(); idle();
    read_reg(CT_A, v);
    check("R11 enable set", v, 8'h01);
    // R7 stack untouched while off: a return now finds it empty
    irq_return = 1'b1; step(); idle();
    check("R7 stack untouched when off", cur_page, 8'h01);
    irq_enter = 1'b1; irq_src = 5'd16; step(); idle();
    check("R4 entry after re-enable", cur_page, 8'h0F);
    irq_return = 1'b1; step(); idle();
    check("R5 restore after re-enable", cur_page, 8'h01);

    // R1 reset in mid-run
    bus_wr = 1'b1; bus_addr = PG_A; bus_wdata = 8'h02; step(); idle();
    irq_enter = 1'b1; irq_src = 5'd0; step(); idle();
    bus_wr = 1'b1; bus_addr = CT_A; bus_wdata = 8'h00; step(); idle();
    rst = 1'b1; step(); rst = 1'b0;
    check("R1 page after second reset", cur_page, 8'h00);
    read_reg(CT_A, v);
    check("R1 enable after second reset", v, 8'h01);
    irq_return = 1'b1; step(); idle();
    check("R1 stack cleared by reset", cur_page, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule